// File: doc/BRIEF.md
# Partitioned Cache Way Allocation Controller

This block chooses the replacement way for one set of an 8-way set-associative cache whose ways are divided into regions by owner. Each request names its source (core 0, core 1, or a stash write from I/O), says whether the lookup hit, and carries the set's valid bits and its tree pseudo-LRU state. On a hit the block returns the refreshed tree state in the same cycle. On a miss it returns, one clock later, whether a line may be allocated, which way to fill, and the tree state after that fill.

Way ownership comes from a configuration write carrying five way masks: core 0 private, core 1 private, shared by both cores, stash-only, and ways used as plain SRAM. A write is checked before it takes effect. A bad write raises an error flag and the old setting stays in force. A core may fill only its own private ways and the shared ways. A stash write may fill only the stash-only ways, and it may be barred from filling at all. Stash traffic and processor traffic therefore never evict each other, and SRAM ways are never handed out.

Top module: `way_alloc_ctrl`

## Requirements
- R1: After reset, every way belongs to the shared region and all other regions are empty. `cfg_err`, `done` and `alloc_en` are low.
- R2: The candidate ways depend on `req_src`. Code 0 (core 0) may use the core 0 ways plus the shared ways. Code 1 (core 1) may use the core 1 ways plus the shared ways. Code 2 (stash) may use only the stash ways. Code 3 has no candidates. SRAM ways are never a candidate.
- R3: A miss with no candidate way completes with `done` high and `alloc_en` low.
- R4: If any candidate way is invalid (its `req_valid_ways` bit is 0), the victim is the lowest-indexed such way.
- R5: If every candidate way is valid, the victim comes from a walk of the tree. Node 0 is the root and node n has children 2n+1 and 2n+2. A left child covers the lower-indexed half of its parent's ways. A node bit of 0 sends the walk left and a bit of 1 sends it right. If the chosen side holds no candidate, the walk takes the other side.
- R6: A miss presented at a clock edge gives `done` high for exactly the following cycle, together with `alloc_en`, `victim_way` and `miss_plru`. When allocating, `miss_plru` is `req_plru` with every node on the victim's path pointed away from it: the bit is 1 if the victim is in the node's left half and 0 otherwise. When not allocating, `miss_plru` equals `req_plru`.
- R7: A hit gives `hit_upd` high and `hit_plru` set to `req_plru` with the hit way's path pointed away from it, in the same cycle. A hit produces no `done` pulse.
- R8: While `stash_alloc_off` is high, a stash miss completes with `alloc_en` low. A stash hit still gives `hit_upd`.
- R9: A configuration write is rejected if any two of the five masks share a way. A rejected write sets `cfg_err` and leaves the previous regions in force. An accepted write clears `cfg_err` and takes effect from the next cycle.
- R10: A configuration write is also rejected if a processor or SRAM region holds a way count other than 0, 1, 2, 4 or 8, or if the stash region holds a way count other than 0, 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core0 | input | WAYS | Core 0 private way mask |
| cfg_core1 | input | WAYS | Core 1 private way mask |
| cfg_shared | input | WAYS | Shared (both cores) way mask |
| cfg_stash | input | WAYS | Stash-only way mask |
| cfg_sram | input | WAYS | SRAM way mask (never allocated) |
| cfg_err | output | 1 | The last configuration write was rejected |
| req_valid | input | 1 | Request present |
| req_src | input | 2 | 0 core 0, 1 core 1, 2 stash, 3 none |
| req_hit | input | 1 | The lookup hit |
| req_hit_way | input | log2(WAYS) | Way that hit |
| req_valid_ways | input | WAYS | Valid bits of the set |
| req_plru | input | WAYS-1 | Current tree state of the set |
| stash_alloc_off | input | 1 | Stash misses do not allocate |
| hit_upd | output | 1 | Hit tree update is valid this cycle |
| hit_plru | output | WAYS-1 | Tree state after the hit |
| done | output | 1 | Miss result is valid |
| alloc_en | output | 1 | The miss may fill `victim_way` |
| victim_way | output | log2(WAYS) | Way chosen for the fill |
| miss_plru | output | WAYS-1 | Tree state after the miss |

## Verification
The bench builds the block with its default of 8 ways, so the tree has 7 node bits and 128 states, and every state can be swept. Under a split configuration it applies every valid-bit pattern for each source. When all candidate ways are valid, it walks all 128 tree states, which reaches each masked turn of the walk, including the turns where the preferred side holds no candidate. A second sweep under the reset configuration runs the unrestricted tree over all eight ways. Separate cases cover rejected and accepted configuration writes, stash denial and hit updates.

// File: rtl/way_alloc_ctrl.sv
module way_alloc_ctrl #(
  parameter int WAYS = 8,
  localparam int IW = $clog2(WAYS)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [WAYS-1:0] cfg_core0,
  input  logic [WAYS-1:0] cfg_core1,
  input  logic [WAYS-1:0] cfg_shared,
  input  logic [WAYS-1:0] cfg_stash,
  input  logic [WAYS-1:0] cfg_sram,
  output logic            cfg_err,
  input  logic            req_valid,
  input  logic [1:0]      req_src,
  input  logic            req_hit,
  input  logic [IW-1:0]   req_hit_way,
  input  logic [WAYS-1:0] req_valid_ways,
  input  logic [WAYS-2:0] req_plru,
  input  logic            stash_alloc_off,
  output logic            hit_upd,
  output logic [WAYS-2:0] hit_plru,
  output logic            done,
  output logic            alloc_en,
  output logic [IW-1:0]   victim_way,
  output logic [WAYS-2:0] miss_plru
);

  logic [WAYS-1:0] c0_q, c1_q, sh_q, st_q, allowed, free_ways;
  logic [IW-1:0]   pick;
  logic            cfg_ok;

  function automatic logic size_ok(input logic [WAYS-1:0] m, input int max);
    int n;
    n = $countones(m);
    return (n == 0) || (((n & (n - 1)) == 0) && n <= max);
  endfunction

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t, input logic [IW-1:0] w);
    logic [WAYS-2:0] r;
    int node;
    r = t;
    for (int l = 0; l < IW; l++) begin
      node = (1 << l) - 1 + (int'(w) >> (IW - l));
      r[node] = ~w[IW-1-l];
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] walk(input logic [WAYS-1:0] m, input logic [WAYS-2:0] t);
    logic [IW-1:0] w;
    int node, pre;
    logic la, ra;
    w = '0;
    for (int l = 0; l < IW; l++) begin
      pre  = int'(w) >> (IW - l);
      node = (1 << l) - 1 + pre;
      la = 1'b0;
      ra = 1'b0;
      for (int k = 0; k < WAYS; k++) begin
        if ((k >> (IW - l - 1)) == 2 * pre)     la = la | m[k];
        if ((k >> (IW - l - 1)) == 2 * pre + 1) ra = ra | m[k];
      end
      w[IW-1-l] = t[node] ? ra : ~la;
    end
    return w;
  endfunction

  assign cfg_ok = size_ok(cfg_core0, WAYS) && size_ok(cfg_core1, WAYS) &&
                  size_ok(cfg_shared, WAYS) && size_ok(cfg_sram, WAYS) &&
                  size_ok(cfg_stash, WAYS / 2) &&
                  ($countones(cfg_core0) + $countones(cfg_core1) + $countones(cfg_shared) +
                   $countones(cfg_stash) + $countones(cfg_sram) ==
                   $countones(cfg_core0 | cfg_core1 | cfg_shared | cfg_stash | cfg_sram));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c0_q <= '0; c1_q <= '0; sh_q <= '1; st_q <= '0; cfg_err <= 1'b0;
    end else if (cfg_we) begin
      cfg_err <= ~cfg_ok;
      if (cfg_ok) begin
        c0_q <= cfg_core0; c1_q <= cfg_core1; sh_q <= cfg_shared; st_q <= cfg_stash;
      end
    end

  always_comb
    case (req_src)
      2'd0:    allowed = c0_q | sh_q;
      2'd1:    allowed = c1_q | sh_q;
      2'd2:    allowed = stash_alloc_off ? '0 : st_q;
      default: allowed = '0;
    endcase

  assign free_ways = allowed & ~req_valid_ways;

  always_comb begin
    pick = walk(allowed, req_plru);
    for (int k = WAYS - 1; k >= 0; k--)
      if (free_ways[k]) pick = IW'(k);
  end

  assign hit_upd  = req_valid & req_hit;
  assign hit_plru = touch(req_plru, req_hit_way);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b0; alloc_en <= 1'b0; victim_way <= '0; miss_plru <= '0;
    end else begin
      done     <= req_valid & ~req_hit;
      alloc_en <= req_valid & ~req_hit & (|allowed);
      if (req_valid && !req_hit) begin
        victim_way <= pick;
        miss_plru  <= (|allowed) ? touch(req_plru, pick) : req_plru;
      end
    end

  a_r6_done_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_hit) |-> done);
  a_r7_hit_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_hit) |-> !done);
  a_r2_victim_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> |($past(allowed) & (WAYS'(1) << victim_way)));
  a_r4_prefers_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && $past(|free_ways)) |-> !(|($past(req_valid_ways) & (WAYS'(1) << victim_way))));
  a_r8_stash_off_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_src == 2'd2 && stash_alloc_off) |-> !alloc_en);
  a_r9_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && cfg_err) |-> ($stable(c0_q) && $stable(c1_q) && $stable(sh_q) && $stable(st_q)));
  a_r3_alloc_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> done);

endmodule

// File: tb/way_alloc_ctrl_test.sv
module way_alloc_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_core0 = '0, cfg_core1 = '0, cfg_shared = '0, cfg_stash = '0, cfg_sram = '0;
  logic cfg_err;
  logic req_valid = 1'b0, req_hit = 1'b0, stash_alloc_off = 1'b0;
  logic [1:0] req_src = '0;
  logic [2:0] req_hit_way = '0;
  logic [7:0] req_valid_ways = '0;
  logic [6:0] req_plru = '0;
  logic hit_upd, done, alloc_en;
  logic [6:0] hit_plru, miss_plru;
  logic [2:0] victim_way;
  int errors = 0, checks = 0;
  logic [7:0] cur_c0, cur_c1, cur_sh, cur_st;

  always #2.5 clk = ~clk;

  way_alloc_ctrl uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] m_touch(input logic [6:0] t, input int w);
    int lo = 0, size = 8, node = 0;
    while (size > 1) begin
      if (w >= lo + size / 2) begin t[node] = 1'b0; lo += size / 2; node = 2 * node + 2; end
      else begin t[node] = 1'b1; node = 2 * node + 1; end
      size /= 2;
    end
    return t;
  endfunction

  function automatic int m_victim(input logic [7:0] m, input logic [7:0] v, input logic [6:0] t);
    int lo = 0, size = 8, node = 0;
    logic lany, rany, right;
    if (m == 0) return -1;
    for (int k = 0; k < 8; k++) if (m[k] && !v[k]) return k;
    while (size > 1) begin
      lany = 1'b0; rany = 1'b0;
      for (int k = 0; k < size / 2; k++) begin
        lany |= m[lo + k]; rany |= m[lo + size / 2 + k];
      end
      right = t[node];
      if (right && !rany) right = 1'b0;
      if (!right && !lany) right = 1'b1;
      if (right) begin lo += size / 2; node = 2 * node + 2; end
      else node = 2 * node + 1;
      size /= 2;
    end
    return lo;
  endfunction

  function automatic logic [7:0] m_allowed(input int src, input logic off);
    case (src)
      0: return cur_c0 | cur_sh;
      1: return cur_c1 | cur_sh;
      2: return off ? 8'h00 : cur_st;
      default: return 8'h00;
    endcase
  endfunction

  task automatic miss(input string tag, input int src, input logic [7:0] v, input logic [6:0] t, input logic off);
    int ev;
    logic [6:0] ep;
    ev = m_victim(m_allowed(src, off), v, t);
    ep = (ev < 0) ? t : m_touch(t, ev);
    req_valid = 1'b1; req_hit = 1'b0; req_src = 2'(src);
    req_valid_ways = v; req_plru = t; stash_alloc_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {19'd0, done, alloc_en, (alloc_en ? victim_way : 3'd0), miss_plru, 1'b0},
               {19'd0, 1'b1, ev >= 0, (ev >= 0 ? 3'(ev) : 3'd0), ep, 1'b0});
  endtask

  task automatic write_cfg(input logic [7:0] a, b, s, st, sr);
    cfg_core0 = a; cfg_core1 = b; cfg_shared = s; cfg_stash = st; cfg_sram = sr; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_c0 = 8'h00; cur_c1 = 8'h00; cur_sh = 8'hFF; cur_st = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {29'd0, cfg_err, done, alloc_en}, 32'd0);

    // R1 R5 unrestricted tree under reset config, all ways valid
    for (int t = 0; t < 128; t++) miss("R5 reset cfg tree", 0, 8'hFF, 7'(t), 1'b0);
    miss("R1 R3 stash empty at reset", 2, 8'h00, 7'h00, 1'b0);
    miss("R2 code 3 no candidates", 3, 8'h00, 7'h00, 1'b0);

    // R9 accepted split config
    write_cfg(8'h01, 8'h02, 8'h30, 8'h0C, 8'hC0);
    cur_c0 = 8'h01; cur_c1 = 8'h02; cur_sh = 8'h30; cur_st = 8'h0C;
    check("R9 accepted write", {31'd0, cfg_err}, 32'd0);

    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 255; v++) miss("R2 R4 invalid sweep", s, 8'(v), 7'h2A, 1'b0);
      for (int t = 0; t < 128; t++) miss("R5 R6 masked tree sweep", s, 8'hFF, 7'(t), 1'b0);
    end

    // R8 stash disable
    for (int v = 0; v < 256; v += 17) miss("R8 stash off miss", 2, 8'(v), 7'h55, 1'b1);
    miss("R8 core unaffected by stash off", 0, 8'hFF, 7'h00, 1'b1);
    req_valid = 1'b1; req_hit = 1'b1; req_src = 2'd2; req_hit_way = 3'd3; req_plru = 7'h00; stash_alloc_off = 1'b1;
    #1 check("R8 stash hit updates", {24'd0, hit_upd, hit_plru}, {24'd0, 1'b1, m_touch(7'h00, 3)});
    stash_alloc_off = 1'b0;

    // R7 hits
    for (int w = 0; w < 8; w++)
      for (int t = 0; t < 128; t += 37) begin
        req_valid = 1'b1; req_hit = 1'b1; req_src = 2'd0; req_hit_way = 3'(w); req_plru = 7'(t);
        #1 check("R7 hit tree update", {24'd0, hit_upd, hit_plru}, {24'd0, 1'b1, m_touch(7'(t), w)});
        @(negedge clk);
        check("R7 hit gives no done", {31'd0, done}, 32'd0);
      end
    req_valid = 1'b0; req_hit = 1'b0;

    // R9 R10 rejected writes keep old config
    write_cfg(8'h03, 8'h02, 8'h30, 8'h0C, 8'hC0);
    check("R9 overlap rejected", {31'd0, cfg_err}, 32'd1);
    miss("R9 old config kept after overlap", 0, 8'hFF, 7'h00, 1'b0);
    write_cfg(8'h07, 8'h00, 8'h00, 8'h00, 8'h00);
    check("R10 size 3 rejected", {31'd0, cfg_err}, 32'd1);
    write_cfg(8'h00, 8'h00, 8'h00, 8'hFF, 8'h00);
    check("R10 stash size 8 rejected", {31'd0, cfg_err}, 32'd1);
    miss("R10 old stash config kept", 2, 8'hFF, 7'h7F, 1'b0);
    write_cfg(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);
    check("R9 R10 sram all accepted clears error", {31'd0, cfg_err}, 32'd0);
    cur_c0 = 8'h00; cur_c1 = 8'h00; cur_sh = 8'h00; cur_st = 8'h00;
    miss("R2 R3 sram ways never allocated", 0, 8'h00, 7'h00, 1'b0);
    write_cfg(8'hF0, 8'h00, 8'h00, 8'h0F, 8'h00);
    cur_c0 = 8'hF0; cur_st = 8'h0F;
    miss("R10 stash four ways accepted", 2, 8'hFF, 7'h00, 1'b0);
    miss("R2 core1 empty", 1, 8'h00, 7'h00, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule